// File: doc/BRIEF.md
# Programmable clock-enable divider unit

This block turns one input clock into three clock-enable strobes for the core, bus and peripheral domains. Logic that runs on the input clock qualifies its flops with one of these strobes, so it advances at a fraction of the input rate without needing a separate derived clock. Software sets the three division ratios through a single control word. That word holds three independent 3-bit fields, and each field indexes a fixed table of ratios. Some of the ratios are not powers of two (3, 5 and 6).

Each write to the control word updates all three ratios together and restarts all three counters from zero. The first strobe after a write therefore arrives one full new period later, and no strobe ever gets a shortened period. Codes outside the officially valid range are not rejected. They act as divide-by-8. A read returns the stored fields, with every bit above them reading as zero.

Top module: `clken_div_top`

## Requirements
- R1: The core ratio is taken from control bits 8:6. Codes 0 to 7 select ratios 1, 2, 3, 4, 5, 8, 8, 8, so codes 6 and 7 behave as divide-by-8.
- R2: The bus ratio is taken from control bits 5:3 and uses the same table as the core: 1, 2, 3, 4, 5, 8, 8, 8 for codes 0 to 7.
- R3: The peripheral ratio is taken from control bits 2:0. Codes 0 to 7 select ratios 2, 3, 4, 6, 8, 8, 8, 8, so codes 5 to 7 behave as divide-by-8.
- R4: While rst is high, the control word is 0 and every strobe is low. After rst is released, core_en and bus_en run at ratio 1 and per_en runs at ratio 2, counted from the first clock edge with rst low.
- R5: A write restarts all three counters. In the cycle right after the write edge every strobe is low. Counting that write edge as edge 0, a strobe with ratio N is high after edges N, 2N, 3N and so on.
- R6: For a ratio N of 2 or more, a strobe is high for exactly one input cycle in every N. For a ratio of 1 the strobe stays high continuously.
- R7: rd_data returns the low 9 bits of the last value written, and all bits above bit 8 read as zero.
- R8: One write updates all three fields together. Each strobe then follows only its own field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Writes wr_data into the control word on this edge |
| wr_data | input | DATA_W | Value to write; bits 8:0 are stored |
| rd_data | output | DATA_W | Stored control word, zero-extended |
| core_en | output | 1 | Core clock-enable strobe |
| bus_en | output | 1 | Bus clock-enable strobe |
| per_en | output | 1 | Peripheral clock-enable strobe |

## Verification
The bench builds the block with its default parameters. A 16-bit data port leaves seven bits above the fields that must read back as zero. A 4-bit counter is just wide enough for the largest ratio, 8. Within this configuration the bench drives every code of every field, including the reserved codes. It includes a write that lands in the middle of a divide-by-8 period, which shows that the restart discards the partial count. Because each strobe is compared cycle by cycle against a pattern computed from the tables, any error in field position, table entry or pulse phase shows up as a wrong value in a specific cycle.

// File: rtl/clken_div_pkg.sv
package clken_div_pkg;
  localparam int FIELD_W     = 3;
  localparam int NUM_STROBES = 3;
  localparam int CTRL_W      = FIELD_W * NUM_STROBES;
  localparam int RATIO_W     = 4;

  // index of each strobe in the enable vector (also its field slot)
  localparam int IDX_PER  = 0;
  localparam int IDX_BUS  = 1;
  localparam int IDX_CORE = 2;

  // core and bus share one table; reserved codes act as divide-by-8
  function automatic logic [RATIO_W-1:0] fast_ratio(input logic [FIELD_W-1:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      3'd0:    r = 4'd1;
      3'd1:    r = 4'd2;
      3'd2:    r = 4'd3;
      3'd3:    r = 4'd4;
      3'd4:    r = 4'd5;
      default: r = 4'd8;
    endcase
    return r;
  endfunction

  // peripheral table; reserved codes act as divide-by-8
  function automatic logic [RATIO_W-1:0] slow_ratio(input logic [FIELD_W-1:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      3'd0:    r = 4'd2;
      3'd1:    r = 4'd3;
      3'd2:    r = 4'd4;
      3'd3:    r = 4'd6;
      default: r = 4'd8;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/clken_div_ctrl.sv
module clken_div_ctrl #(
  parameter int DATA_W = 16,
  parameter int CTRL_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAD_W = DATA_W - CTRL_W;

  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= '0;
    else if (wr_en)
      ctrl_q <= wr_data[CTRL_W-1:0];
  end

  assign rd_data = {{PAD_W{1'b0}}, ctrl_q};
endmodule

// File: rtl/clken_div_strobe.sv
module clken_div_strobe #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [CNT_W-1:0] ratio,
  output logic             en
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             at_end;

  assign at_end = (cnt == ratio - ONE);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
      en  <= 1'b0;
    end else if (at_end) begin
      cnt <= '0;
      en  <= 1'b1;
    end else begin
      cnt <= cnt + ONE;
      en  <= 1'b0;
    end
  end
endmodule

// File: rtl/clken_div_top.sv
module clken_div_top
  import clken_div_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = RATIO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              core_en,
  output logic              bus_en,
  output logic              per_en
);
  logic [CTRL_W-1:0]      ctrl_q;
  logic [NUM_STROBES-1:0] en_vec;

  clken_div_ctrl #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) ctrl_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .rd_data(rd_data)
  );

  for (genvar g = 0; g < NUM_STROBES; g++) begin : g_strobe
    logic [FIELD_W-1:0] code;
    logic [CNT_W-1:0]   ratio;
    assign code = ctrl_q[g*FIELD_W +: FIELD_W];
    if (g == IDX_PER) begin : g_slow
      assign ratio = CNT_W'(slow_ratio(code));
    end else begin : g_fast
      assign ratio = CNT_W'(fast_ratio(code));
    end
    clken_div_strobe #(.CNT_W(CNT_W)) div_i (
      .clk(clk), .rst(rst), .restart(wr_en), .ratio(ratio), .en(en_vec[g])
    );
  end

  assign per_en  = en_vec[IDX_PER];
  assign bus_en  = en_vec[IDX_BUS];
  assign core_en = en_vec[IDX_CORE];
endmodule

// File: rtl/clken_div_chk.sv
module clken_div_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              core_en,
  input logic              bus_en,
  input logic              per_en
);
  p_reset_quiet_r4: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !core_en && !bus_en && !per_en));

  p_write_clears_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (!core_en && !bus_en && !per_en));

  p_readback_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data == DATA_W'($past(wr_data[8:0]))));

  p_ratio1_core_r6: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && rd_data[8:6] == 3'd0) |=> core_en);

  p_ratio1_bus_r2: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && rd_data[5:3] == 3'd0) |=> bus_en);

  p_per_single_r3: assert property (@(posedge clk) disable iff (rst)
    per_en |=> !per_en);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data));
endmodule

bind clken_div_top clken_div_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .core_en(core_en), .bus_en(bus_en), .per_en(per_en)
);

// File: tb/clken_div_tb.sv
module clken_div_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic core_en, bus_en, per_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic  c;
    logic  b;
    logic  p;
    string tag;
  } exp_t;

  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  clken_div_top #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .core_en(core_en), .bus_en(bus_en), .per_en(per_en)
  );

  function automatic int tab_fast(input logic [2:0] c);
    case (c)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 4;
      3'd4: return 5;
      default: return 8;
    endcase
  endfunction

  function automatic int tab_slow(input logic [2:0] c);
    case (c)
      3'd0: return 2;
      3'd1: return 3;
      3'd2: return 4;
      3'd3: return 6;
      default: return 8;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push_window(input int cr, input int br, input int pr,
                             input int n, input string tag);
    for (int j = 1; j <= n; j++) begin
      exp_t it;
      it.c = (j % cr) == 0;
      it.b = (j % br) == 0;
      it.p = (j % pr) == 0;
      it.tag = tag;
      q.push_back(it);
    end
  endtask

  task automatic do_write(input logic [DW-1:0] d, input int n, input string tag);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    check(rd_data == {7'b0, d[8:0]}, "R7", "rd_data", rd_data, {7'b0, d[8:0]});
    check({core_en, bus_en, per_en} == 3'b000, "R5", "strobes after write",
          DW'({core_en, bus_en, per_en}), '0);
    #1;
    push_window(tab_fast(d[8:6]), tab_fast(d[5:3]), tab_slow(d[2:0]), n, tag);
    wait (q.size() == 0);
  endtask

  // monitor: compares each cycle of the expected pattern
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        exp_t it;
        it = q.pop_front();
        check(core_en == it.c, it.tag, "core_en", DW'(core_en), DW'(it.c));
        check(bus_en  == it.b, it.tag, "bus_en",  DW'(bus_en),  DW'(it.b));
        check(per_en  == it.p, it.tag, "per_en",  DW'(per_en),  DW'(it.p));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R4: reset state, then default ratios 1, 1, 2
    repeat (3) @(negedge clk);
    check(rd_data == '0, "R4", "rd_data in reset", rd_data, '0);
    check({core_en, bus_en, per_en} == 3'b000, "R4", "strobes in reset",
          DW'({core_en, bus_en, per_en}), '0);
    rst = 1'b0;
    #1;
    push_window(1, 1, 2, 12, "R4 R6");
    wait (q.size() == 0);

    // R1 R2 R3 R8: distinct codes in each field
    do_write({7'b0, 3'd2, 3'd4, 3'd1}, 40, "R1 R2 R3 R8");
    do_write({7'b0, 3'd4, 3'd3, 3'd3}, 60, "R1 R2 R3 R8");
    do_write({7'b0, 3'd1, 3'd2, 3'd2}, 24, "R1 R2 R3 R5");
    do_write({7'b0, 3'd3, 3'd1, 3'd0}, 24, "R1 R2 R3 R6");
    do_write({7'b0, 3'd5, 3'd0, 3'd4}, 24, "R1 R2 R3 R6");
    // reserved codes clamp to divide-by-8
    do_write({7'b0, 3'd6, 3'd7, 3'd5}, 24, "R1 R2 R3 reserved");
    do_write({7'b0, 3'd7, 3'd6, 3'd6}, 24, "R1 R2 R3 reserved");
    do_write({7'b0, 3'd0, 3'd5, 3'd7}, 24, "R1 R2 R3 R6");
    // R5: write in the middle of a divide-by-8 period restarts the count
    do_write({7'b0, 3'd5, 3'd5, 3'd4}, 3, "R5 mid");
    do_write({7'b0, 3'd5, 3'd5, 3'd4}, 20, "R5 restart");
    do_write({7'b0, 3'd5, 3'd5, 3'd4}, 5, "R5 mid");
    do_write({7'b0, 3'd2, 3'd3, 3'd1}, 30, "R5 R8 restart");
    // R7: upper bits written as ones read back as zero
    do_write({7'h7F, 3'd1, 3'd4, 3'd3}, 30, "R7 R8");
    do_write(16'hFFFF, 16, "R7 reserved");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule